// File: doc/BRIEF.md
# UART Double-Buffered Receive Path

This block is the data half of a UART receiver. An outside sampler finds the start bit and then gives one strobe per received bit, in the middle of each bit cell. The block collects those bits, least significant first, into a first-stage shift register. When a whole frame has arrived, it moves the frame into a holding register that the CPU reads, and it raises a one-cycle receive interrupt.

The shift register and the holding register form a double buffer. The next frame can assemble while the CPU has not yet read the last one. If the CPU is still too slow when that next frame completes, the new frame is dropped, the old contents stay in place, and a sticky overrun flag is set.

A frame can have 7 or 8 data bits. It can also carry a ninth bit, which is stored in its own register. That bit is the received parity bit in 8-bit-plus-parity mode, or the data MSB in 9-bit mode. In 9-bit mode, a wake-up filter can hide frames whose ninth bit is 0. This lets a multiprocessor slave be interrupted only by address frames.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `rx_data`, `rx_ninth`, `rx_irq` and `rx_ovr` are all 0 and the holding register is empty.
- R2: Bits are taken from `rx_bit` only in cycles where `bit_stb` is 1, and the k-th strobe of a frame lands in bit k of the frame, counting from 0 (LSB first). On the frame's last strobe the frame is transferred. `rx_data` shows it in the next cycle, and `rx_irq` is 1 for exactly that one cycle.
- R3: `frame_mode` = 0 selects 7 data bits: 7 strobes make a frame, `rx_data[7]` reads 0 and `rx_ninth` reads 0.
- R4: `frame_mode` = 1 selects 8 data bits: 8 strobes make a frame and `rx_ninth` reads 0.
- R5: `frame_mode` = 2 selects 8 data bits plus parity: 9 strobes make a frame, and the ninth (last) bit, the parity bit, appears on `rx_ninth`.
- R6: `frame_mode` = 3 selects 9-bit mode: 9 strobes make a frame, and the ninth (last) bit, the data MSB, appears on `rx_ninth`.
- R7: A new frame may assemble while the holding register is full. A pulse on `rd_stb` empties the holding register. A read in the same cycle as a frame's last strobe counts as happening first, so that frame is accepted.
- R8: If a frame completes while the holding register is full and unread, the frame is discarded: `rx_data` and `rx_ninth` keep their values, no `rx_irq` is raised, and `rx_ovr` goes to 1.
- R9: `rx_ovr` stays 1 until a pulse on `ovr_clr`, including across reads. If a new overrun and `ovr_clr` happen in the same cycle, the overrun wins.
- R10: With `frame_mode` = 3 and `wake_en` = 1, a frame whose ninth bit is 0 is stored and fills the holding register but raises no `rx_irq`, while a frame whose ninth bit is 1 raises it. In modes 0 to 2, `wake_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial data value at the sampling point |
| bit_stb | input | 1 | One-cycle strobe: sample `rx_bit` now |
| frame_mode | input | 2 | 0: 7 data bits, 1: 8 data bits, 2: 8 data bits + parity, 3: 9-bit |
| wake_en | input | 1 | Wake-up filter enable (acts in 9-bit mode only) |
| rd_stb | input | 1 | CPU read of the holding register |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Holding register |
| rx_ninth | output | 1 | Stored ninth bit (parity or MSB) |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
- A bit counter that is off by one shows up at the next frame boundary. Either `rx_irq` fires one strobe early or late, or `rx_data` comes out shifted by one place. Both can be seen one cycle after the final strobe.
- A full status that fails to clear on a read shows up as a false overrun on the very next frame.
- A full status that fails to set hides an overrun: the second unread frame overwrites `rx_data` instead of raising `rx_ovr`.
- Wake-filter mistakes show up at once as a missing or extra `rx_irq` in the cycle after transfer, while `rx_data` still updates.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      FM_SEVEN     = 2'd0,
      FM_EIGHT     = 2'd1,
      FM_EIGHT_PAR = 2'd2,
      FM_NINE      = 2'd3
   } frame_mode_e;
endpackage

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
   import uart_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SHORT_W   = 7,
   parameter bit HAS_NINTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              rx_bit,
   input  frame_mode_e       mode,
   output logic              done,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_ninth
);
   localparam int FW = DATA_W + 1;
   localparam int IW = $clog2(FW);

   if (SHORT_W < 1 || SHORT_W >= DATA_W) begin : g_bad_short
      $error("uart_rx_shifter: SHORT_W must lie in 1..DATA_W-1");
   end

   logic [FW-1:0] sh_q, sh_nxt;
   logic [IW-1:0] cnt_q, last_idx;

   // Index of the final bit of a frame for the selected mode
   if (HAS_NINTH) begin : g_ninth
      always_comb begin
         unique case (mode)
            FM_SEVEN: last_idx = IW'(SHORT_W - 1);
            FM_EIGHT: last_idx = IW'(DATA_W - 1);
            default:  last_idx = IW'(DATA_W);
         endcase
      end
   end else begin : g_no_ninth
      always_comb last_idx = (mode == FM_SEVEN) ? IW'(SHORT_W - 1) : IW'(DATA_W - 1);
   end

   always_comb begin
      sh_nxt = sh_q;
      if (bit_stb) sh_nxt[cnt_q] = rx_bit;
   end

   assign done      = bit_stb && (cnt_q >= last_idx);
   assign frm_data  = sh_nxt[DATA_W-1:0];
   assign frm_ninth = HAS_NINTH ? sh_nxt[DATA_W] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (done) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (bit_stb) begin
         cnt_q <= cnt_q + 1'b1;
         sh_q  <= sh_nxt;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= IW'(DATA_W)); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
   import uart_rx_pkg::*;
#(
   parameter bit HAS_NINTH = 1'b1
) (
   input  frame_mode_e mode,
   input  logic        wake_en,
   input  logic        frm_ninth,
   output logic        irq_ok
);
   if (HAS_NINTH) begin : g_filter
      assign irq_ok = !(wake_en && (mode == FM_NINE) && !frm_ninth);
   end else begin : g_pass
      assign irq_ok = 1'b1;
   end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_ninth,
   input  logic              irq_ok,
   input  logic              rd_stb,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] hold_q,
   output logic              ninth_q,
   output logic              irq_q,
   output logic              ovr_q
);
   if (DATA_W < 2) begin : g_bad_width
      $error("uart_rx_hold: DATA_W must be at least 2");
   end

   logic full_q;
   logic accept, ovr_ev;

   // A read in the completing cycle frees the slot first
   assign accept = done && (!full_q || rd_stb);
   assign ovr_ev = done && full_q && !rd_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         hold_q  <= '0;
         ninth_q <= 1'b0;
         irq_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         irq_q <= accept && irq_ok;
         if (accept) begin
            full_q  <= 1'b1;
            hold_q  <= frm_data;
            ninth_q <= frm_ninth;
         end else if (rd_stb) begin
            full_q  <= 1'b0;
         end
         if (ovr_ev)       ovr_q <= 1'b1;
         else if (ovr_clr) ovr_q <= 1'b0;
      end
   end

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q); // R2
   AST_IRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> full_q); // R7
   AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_ev |=> ($stable(hold_q) && $stable(ninth_q) && !irq_q && ovr_q)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !ovr_clr) |=> ovr_q); // R9
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
   import uart_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SHORT_W   = 7,
   parameter bit HAS_NINTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic              bit_stb,
   input  logic [1:0]        frame_mode,
   input  logic              wake_en,
   input  logic              rd_stb,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ninth,
   output logic              rx_irq,
   output logic              rx_ovr
);
   frame_mode_e       mode;
   logic              done, frm_ninth, irq_ok;
   logic [DATA_W-1:0] frm_data;

   assign mode = frame_mode_e'(frame_mode);

   uart_rx_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .HAS_NINTH(HAS_NINTH)) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit), .mode(mode),
      .done(done), .frm_data(frm_data), .frm_ninth(frm_ninth)
   );

   uart_rx_wake #(.HAS_NINTH(HAS_NINTH)) u_wake (
      .mode(mode), .wake_en(wake_en), .frm_ninth(frm_ninth), .irq_ok(irq_ok)
   );

   uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .done(done), .frm_data(frm_data), .frm_ninth(frm_ninth),
      .irq_ok(irq_ok), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
      .hold_q(rx_data), .ninth_q(rx_ninth), .irq_q(rx_irq), .ovr_q(rx_ovr)
   );

   AST_WAKE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode == FM_NINE && wake_en && !frm_ninth) |=> !rx_irq); // R10
   AST_SEVEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && $past(mode) == FM_SEVEN) |-> !rx_data[DATA_W-1]); // R3
endmodule

// File: tb/uart_rx_dbuf_tb.sv
module uart_rx_dbuf_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b0, bit_stb = 1'b0, wake_en = 1'b0, rd_stb = 1'b0, ovr_clr = 1'b0;
   logic [1:0] frame_mode = 2'd1;
   logic [7:0] rx_data;
   logic       rx_ninth, rx_irq, rx_ovr;
   int         checks = 0, failures = 0;
   logic       irq_a, irq_b;

   always #5 clk = ~clk;

   uart_rx_dbuf u_dut (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_stb(bit_stb), .frame_mode(frame_mode),
      .wake_en(wake_en), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
      .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Sends n bits LSB first; irq_a is sampled in the cycle after the last strobe, irq_b one later
   task automatic send(input logic [8:0] val, input int n, input bit rd_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_bit  = val[i];
         bit_stb = 1'b1;
         rd_stb  = rd_last && (i == n - 1);
         @(negedge clk);
         bit_stb = 1'b0;
         rd_stb  = 1'b0;
         rx_bit  = ~val[i];
         if (i != n - 1) begin
            @(negedge clk);
         end
      end
      irq_a = rx_irq;
      @(negedge clk);
      irq_b = rx_irq;
   endtask

   task automatic cpu_read();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "rx_data", rx_data, 0);
      check("R1", "rx_ninth", rx_ninth, 0);
      check("R1", "rx_irq", rx_irq, 0);
      check("R1", "rx_ovr", rx_ovr, 0);
   endtask

   task automatic t_eight();
      frame_mode = 2'd1;
      send(9'h0A5, 8, 1'b0);
      check("R2", "irq in cycle after last strobe", irq_a, 1);
      check("R2", "irq width one cycle", irq_b, 0);
      check("R4", "8-bit data", rx_data, 8'hA5);
      check("R4", "ninth in 8-bit mode", rx_ninth, 0);
      cpu_read();
   endtask

   task automatic t_seven();
      frame_mode = 2'd0;
      send(9'h0D3, 7, 1'b0);
      check("R3", "irq after 7 strobes", irq_a, 1);
      check("R3", "7-bit data, top bit 0", rx_data, 8'h53);
      check("R3", "ninth in 7-bit mode", rx_ninth, 0);
      cpu_read();
   endtask

   task automatic t_parity();
      frame_mode = 2'd2;
      send(9'h13C, 9, 1'b0);
      check("R5", "irq after 9 strobes", irq_a, 1);
      check("R5", "data with parity", rx_data, 8'h3C);
      check("R5", "parity bit", rx_ninth, 1);
   endtask

   task automatic t_overrun();
      // Holding register still full from t_parity
      send(9'h011, 9, 1'b0);
      check("R8", "no irq on overrun", irq_a, 0);
      check("R8", "data kept", rx_data, 8'h3C);
      check("R8", "ninth kept", rx_ninth, 1);
      check("R8", "overrun flag", rx_ovr, 1);
      cpu_read();
      check("R9", "overrun sticky over read", rx_ovr, 1);
      frame_mode = 2'd1;
      send(9'h066, 8, 1'b0);
      check("R7", "frame accepted after read", rx_data, 8'h66);
      check("R7", "irq after read", irq_a, 1);
      check("R9", "overrun still set", rx_ovr, 1);
      // Overrun and clear in the same cycle: set wins
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rx_bit = 1'b1; bit_stb = 1'b1; ovr_clr = (i == 7);
         @(negedge clk);
         bit_stb = 1'b0; ovr_clr = 1'b0;
      end
      check("R9", "set wins over clear", rx_ovr, 1);
      check("R8", "data kept on 2nd overrun", rx_data, 8'h66);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      check("R9", "overrun cleared", rx_ovr, 0);
      cpu_read();
   endtask

   task automatic t_same_cycle_read();
      frame_mode = 2'd1;
      send(9'h0C3, 8, 1'b0);
      send(9'h05A, 8, 1'b1);
      check("R7", "read on last strobe accepts", rx_data, 8'h5A);
      check("R7", "no overrun", rx_ovr, 0);
      check("R7", "irq", irq_a, 1);
      cpu_read();
   endtask

   task automatic t_wake();
      frame_mode = 2'd3;
      wake_en    = 1'b1;
      send(9'h077, 9, 1'b0);
      check("R10", "data frame muted", irq_a, 0);
      check("R10", "data frame still stored", rx_data, 8'h77);
      check("R6", "ninth bit MSB 0", rx_ninth, 0);
      send(9'h012, 9, 1'b0);
      check("R10", "muted frame filled buffer -> overrun", rx_ovr, 1);
      check("R10", "data kept", rx_data, 8'h77);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      cpu_read();
      send(9'h1A9, 9, 1'b0);
      check("R10", "address frame interrupts", irq_a, 1);
      check("R6", "9-bit low data", rx_data, 8'hA9);
      check("R6", "ninth bit MSB 1", rx_ninth, 1);
      cpu_read();
      frame_mode = 2'd2;
      send(9'h044, 9, 1'b0);
      check("R10", "wake ignored in parity mode", irq_a, 1);
      check("R10", "parity mode data", rx_data, 8'h44);
      wake_en = 1'b0;
      cpu_read();
      frame_mode = 2'd3;
      send(9'h0E1, 9, 1'b0);
      check("R6", "no filter without wake_en", irq_a, 1);
      check("R6", "9-bit data", rx_data, 8'hE1);
      cpu_read();
   endtask

   task automatic t_idle_strobe();
      // Bits presented without strobes must not be taken (R2)
      frame_mode = 2'd1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rx_bit = 1'b1;
      end
      send(9'h081, 8, 1'b0);
      check("R2", "only strobed bits collected", rx_data, 8'h81);
      cpu_read();
   endtask

   logic finished = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R0 watchdog: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_eight();
      t_seven();
      t_parity();
      t_overrun();
      t_same_cycle_read();
      t_wake();
      t_idle_strobe();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule